// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing register file for a three-channel interval timer. A host reaches it through a 2-bit address with 8-bit write and read strobes. Addresses 0, 1 and 2 select the count registers of channels 0, 1 and 2. Address 3 is a control register that can only be written. Control words choose a channel, a byte access mode, an operating mode and a decimal-count flag. Two kinds of control word do not change settings: the counter latch command and the read-back command.

The block turns byte writes into 16-bit load values and sends each one to its channel with a one-cycle load pulse. It also presents every channel's operating mode and decimal flag. It takes each channel's live count and output level as inputs. Count snapshots and status snapshots are held inside the block until the host reads them. The count-latch pulse to a channel fires only when a snapshot is actually taken.

Read data is combinational. It is valid during the cycle in which `rd_en` is high. Read side effects, such as advancing a byte sequencer or clearing a latch, take effect at the clock edge that ends that cycle. Load values, load pulses and latch pulses are registered, so they appear one cycle after the write that causes them.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset, every channel uses access mode 1 (low byte only), operating mode 0, decimal flag 0, and has nothing latched. All load and latch pulses are low, so a read of channel c returns the low byte of its live count.
- R2: A control word is decoded by field. Bits 7:6 are the channel and bits 5:4 are the access mode. Bits 3:1 are the operating mode and bit 0 is the decimal flag. When the access mode is not 0, the channel's `mode_o` and `bcd_o` take the new values on the next cycle.
- R3: In access mode 1, one data write loads {8'h00, byte}. In access mode 2, one data write loads {byte, 8'h00}. In both cases `load_stb[c]` pulses for one cycle and `load_val` carries the value, both in the cycle after the write.
- R4: In access mode 3, the first data write is only held. The second write loads {second, first} and pulses `load_stb`. The next write is again treated as a low byte.
- R5: A control word with access field 0 is a counter latch command. It snapshots the channel's count, pulses `snap_stb[c]` on the next cycle, and leaves the mode, decimal flag and access mode unchanged.
- R6: A count-latch request is ignored while an earlier count snapshot is still unread. A status-latch request is ignored while an earlier status snapshot is still unread. An ignored count request gives no `snap_stb` pulse.
- R7: A control word with channel field 3 is a read-back command. Bit 1+c selects channel c, and several channels may be selected at once. Bit 5 = 0 latches the count and bit 4 = 0 latches the status.
- R8: The status byte is {output level, 1'b0, access mode[1:0], operating mode[2:0], decimal flag}.
- R9: A data read returns the latched status first and clears it. If no status is latched, it returns the latched count instead. In access mode 1 or 2 the latched count is one byte and then the latch is released. In access mode 3 it is low then high. If nothing is latched, the read returns the live count.
- R10: Reading address 3 returns 8'h00 and changes no state.
- R11: In access mode 3, unlatched reads alternate between the low and high byte of the live count, starting with the low byte.
- R12: A control word that sets an access mode returns that channel's read and write byte sequencers to the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0-2 for channel counts, 3 for control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| load_val | output | 48 | Load value per channel, channel c in bits 16c+15:16c |
| load_stb | output | 3 | One-cycle load pulse per channel |
| mode_o | output | 9 | Operating mode per channel, channel c in bits 3c+2:3c |
| bcd_o | output | 3 | Decimal-count flag per channel |
| snap_stb | output | 3 | One-cycle pulse when a count snapshot is taken |
| cnt_in | input | 48 | Live count per channel, same packing as load_val |
| out_in | input | 3 | Output level per channel |

## Verification
Directed sequences cover each access mode with distinct byte values. These show whether a byte lands in the low or the high half, and whether a held low byte is kept separate from a load. The live count is changed between the latch command and the reads. This shows whether a read returns the snapshot or the live value, and whether a second latch request is ignored. Read-back commands select several channels and set different output levels, which checks status-before-count ordering and the status field positions. A long seeded random mix of control words, data writes and reads then interleaves sequencer resets with half-finished byte pairs across all three channels.

// File: rtl/tmr_host_regs.sv
module tmr_host_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [47:0] load_val,
  output logic [2:0]  load_stb,
  output logic [8:0]  mode_o,
  output logic [2:0]  bcd_o,
  output logic [2:0]  snap_stb,
  input  logic [47:0] cnt_in,
  input  logic [2:0]  out_in
);
  localparam int NCH = 3;

  logic [1:0]  acc_q [4];
  logic [2:0]  mode_q[4];
  logic        bcd_q [4];
  logic        whi_q [4];
  logic        rhi_q [4];
  logic [7:0]  wl_q  [4];
  logic [1:0]  cl_q  [4];
  logic [15:0] lc_q  [4];
  logic        sv_q  [4];
  logic [7:0]  st_q  [4];
  logic [15:0] cnt_w [4];

  logic rb_cmd, ctl_cmd, dat_wr, rd_ch;
  logic [2:0] lat_req, st_req;
  logic [15:0] live;
  logic live_hi;

  assign cnt_w[0] = cnt_in[15:0];
  assign cnt_w[1] = cnt_in[31:16];
  assign cnt_w[2] = cnt_in[47:32];
  assign cnt_w[3] = 16'h0000;

  assign rb_cmd  = wr_en && addr == 2'd3 && wdata[7:6] == 2'd3;
  assign ctl_cmd = wr_en && addr == 2'd3 && wdata[7:6] != 2'd3;
  assign dat_wr  = wr_en && addr != 2'd3;
  assign rd_ch   = rd_en && addr != 2'd3;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lat_req[i] = (rb_cmd && wdata[i+1] && !wdata[5]) ||
                   (ctl_cmd && wdata[7:6] == 2'(i) && wdata[5:4] == 2'd0);
      st_req[i]  = rb_cmd && wdata[i+1] && !wdata[4];
    end
  end

  assign live    = cnt_w[addr];
  assign live_hi = acc_q[addr] == 2'd2 || (acc_q[addr] == 2'd3 && rhi_q[addr]);

  always_comb begin
    rdata = 8'h00;
    if (addr != 2'd3) begin
      if (sv_q[addr])              rdata = st_q[addr];
      else if (cl_q[addr] == 2'd2) rdata = lc_q[addr][15:8];
      else if (cl_q[addr] != 2'd0) rdata = lc_q[addr][7:0];
      else                         rdata = live_hi ? live[15:8] : live[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        acc_q[i]  <= 2'd1;
        mode_q[i] <= 3'd0;
        bcd_q[i]  <= 1'b0;
        whi_q[i]  <= 1'b0;
        rhi_q[i]  <= 1'b0;
        wl_q[i]   <= 8'h00;
        cl_q[i]   <= 2'd0;
        lc_q[i]   <= 16'h0000;
        sv_q[i]   <= 1'b0;
        st_q[i]   <= 8'h00;
      end
      load_val <= '0;
      load_stb <= '0;
      snap_stb <= '0;
    end else begin
      load_stb <= '0;
      snap_stb <= '0;
      if (rd_ch) begin
        if (sv_q[addr])              sv_q[addr] <= 1'b0;
        else if (cl_q[addr] == 2'd3) cl_q[addr] <= 2'd2;
        else if (cl_q[addr] != 2'd0) cl_q[addr] <= 2'd0;
        else if (acc_q[addr] == 2'd3) rhi_q[addr] <= !rhi_q[addr];
      end
      for (int i = 0; i < NCH; i++) begin
        if (lat_req[i] && cl_q[i] == 2'd0) begin
          lc_q[i]     <= cnt_w[i];
          cl_q[i]     <= acc_q[i];
          snap_stb[i] <= 1'b1;
        end
        if (st_req[i] && !sv_q[i]) begin
          st_q[i] <= {out_in[i], 1'b0, acc_q[i], mode_q[i], bcd_q[i]};
          sv_q[i] <= 1'b1;
        end
      end
      if (ctl_cmd && wdata[5:4] != 2'd0) begin
        acc_q[wdata[7:6]]  <= wdata[5:4];
        mode_q[wdata[7:6]] <= wdata[3:1];
        bcd_q[wdata[7:6]]  <= wdata[0];
        whi_q[wdata[7:6]]  <= 1'b0;
        rhi_q[wdata[7:6]]  <= 1'b0;
      end
      if (dat_wr) begin
        case (acc_q[addr])
          2'd2: begin
            load_val[16*addr +: 16] <= {wdata, 8'h00};
            load_stb[addr] <= 1'b1;
          end
          2'd3: begin
            if (!whi_q[addr]) begin
              wl_q[addr]  <= wdata;
              whi_q[addr] <= 1'b1;
            end else begin
              load_val[16*addr +: 16] <= {wdata, wl_q[addr]};
              load_stb[addr] <= 1'b1;
              whi_q[addr] <= 1'b0;
            end
          end
          default: begin
            load_val[16*addr +: 16] <= {8'h00, wdata};
            load_stb[addr] <= 1'b1;
          end
        endcase
      end
    end
  end

  assign mode_o = {mode_q[2], mode_q[1], mode_q[0]};
  assign bcd_o  = {bcd_q[2], bcd_q[1], bcd_q[0]};

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 2'(g) && acc_q[g] == 2'd3 && !whi_q[g] |=> !load_stb[g]);
    // R6
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cl_q[g] != 2'd0 && !(rd_en && addr == 2'(g)) |=> $stable(lc_q[g]));
    // R9
    status_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !wr_en && addr == 2'(g) && sv_q[g] |=> !sv_q[g] && $stable(cl_q[g]));
    // R12
    seq_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 2'd3 && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0
      |=> !whi_q[g] && !rhi_q[g]);
    // R5
    snap_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_stb[g] |-> cl_q[g] != 2'd0);
  end
endmodule

// File: tb/test_tmr_host_regs.sv
module test_tmr_host_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [47:0] load_val;
  logic [2:0]  load_stb, bcd_o, snap_stb;
  logic [8:0]  mode_o;
  logic [47:0] cnt_in = 0;
  logic [2:0]  out_in = 0;

  int total = 0, bad = 0;
  logic [7:0] got;

  int m_acc[3], m_mode[3], m_bcd[3], m_whi[3], m_rhi[3], m_wl[3];
  int m_cl[3], m_lc[3], m_sv[3], m_st[3];
  logic [47:0] m_ld;

  always #2 clk = ~clk;

  tmr_host_regs i_tmr_host_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .load_val(load_val), .load_stb(load_stb),
    .mode_o(mode_o), .bcd_o(bcd_o), .snap_stb(snap_stb),
    .cnt_in(cnt_in), .out_in(out_in));

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(int c);
    return int'(cnt_in[16*c +: 16]);
  endfunction

  task automatic take_latch(int c, ref logic [2:0] snap);
    if (m_cl[c] == 0) begin
      m_lc[c] = cnt_of(c);
      m_cl[c] = m_acc[c];
      snap[c] = 1'b1;
    end
  endtask

  task automatic op(bit wr, bit [1:0] a, bit [7:0] d, string tag);
    logic [7:0] e_rd = 8'h00;
    logic [2:0] e_stb = 0, e_snap = 0;
    int c = int'(a);
    if (!wr) begin
      if (a != 3) begin
        if (m_sv[c] != 0) begin
          e_rd = 8'(m_st[c]); m_sv[c] = 0;
        end else if (m_cl[c] != 0) begin
          e_rd = (m_cl[c] == 2) ? 8'(m_lc[c] >> 8) : 8'(m_lc[c]);
          m_cl[c] = (m_cl[c] == 3) ? 2 : 0;
        end else begin
          bit hi = m_acc[c] == 2 || (m_acc[c] == 3 && m_rhi[c] != 0);
          e_rd = hi ? 8'(cnt_of(c) >> 8) : 8'(cnt_of(c));
          if (m_acc[c] == 3) m_rhi[c] = 1 - m_rhi[c];
        end
      end
    end else if (a == 3) begin
      if (d[7:6] == 3) begin
        for (int i = 0; i < 3; i++) if (d[i+1]) begin
          if (!d[5]) take_latch(i, e_snap);
          if (!d[4] && m_sv[i] == 0) begin
            m_st[i] = (int'(out_in[i]) << 7) | (m_acc[i] << 4) | (m_mode[i] << 1) | m_bcd[i];
            m_sv[i] = 1;
          end
        end
      end else if (d[5:4] == 0) begin
        take_latch(int'(d[7:6]), e_snap);
      end else begin
        int k = int'(d[7:6]);
        m_acc[k] = int'(d[5:4]); m_mode[k] = int'(d[3:1]); m_bcd[k] = int'(d[0]);
        m_whi[k] = 0; m_rhi[k] = 0;
      end
    end else begin
      if (m_acc[c] == 1) begin m_ld[16*c +: 16] = {8'h00, d}; e_stb[c] = 1; end
      else if (m_acc[c] == 2) begin m_ld[16*c +: 16] = {d, 8'h00}; e_stb[c] = 1; end
      else if (m_whi[c] == 0) begin m_wl[c] = int'(d); m_whi[c] = 1; end
      else begin m_ld[16*c +: 16] = {d, 8'(m_wl[c])}; e_stb[c] = 1; m_whi[c] = 0; end
    end
    @(negedge clk);
    addr = a; wdata = d; wr_en = wr; rd_en = !wr;
    #1;
    if (!wr) begin got = rdata; chk(tag, 48'(rdata), 48'(e_rd)); end
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
    chk(tag, 48'(load_stb), 48'(e_stb));
    chk(tag, 48'(snap_stb), 48'(e_snap));
    chk(tag, load_val, m_ld);
    chk(tag, 48'({mode_o, bcd_o}),
        48'({3'(m_mode[2]), 3'(m_mode[1]), 3'(m_mode[0]), 1'(m_bcd[2]), 1'(m_bcd[1]), 1'(m_bcd[0])}));
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    for (int i = 0; i < 3; i++) begin
      m_acc[i] = 1; m_mode[i] = 0; m_bcd[i] = 0; m_whi[i] = 0; m_rhi[i] = 0;
      m_wl[i] = 0; m_cl[i] = 0; m_lc[i] = 0; m_sv[i] = 0; m_st[i] = 0;
    end
    m_ld = 0;
    cnt_in = 48'h0000_0000_1234;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1", 48'(load_stb), 0);
    chk("R1", 48'({mode_o, bcd_o}), 0);
    op(0, 0, 0, "R1"); chk("R1", 48'(got), 48'h34);

    op(1, 3, 8'h6B, "R2");
    chk("R2", 48'(mode_o[5:3]), 48'd5); chk("R2", 48'(bcd_o[1]), 1);
    op(1, 1, 8'h7F, "R3"); chk("R3", load_val[31:16], 48'h7F00);
    op(1, 3, 8'h54, "R2");
    op(1, 1, 8'h11, "R3"); chk("R3", load_val[31:16], 48'h0011);

    op(1, 3, 8'h34, "R2");
    op(1, 0, 8'hCD, "R4");
    op(1, 0, 8'hAB, "R4"); chk("R4", load_val[15:0], 48'hABCD);
    op(1, 0, 8'h01, "R4");
    op(1, 3, 8'h34, "R12");
    op(1, 0, 8'h66, "R12");
    op(1, 0, 8'h77, "R12"); chk("R12", load_val[15:0], 48'h7766);

    cnt_in[15:0] = 16'hBEEF;
    op(0, 0, 0, "R11"); chk("R11", 48'(got), 48'hEF);
    op(1, 3, 8'h34, "R12");
    op(0, 0, 0, "R12"); chk("R12", 48'(got), 48'hEF);
    op(0, 0, 0, "R11"); chk("R11", 48'(got), 48'hBE);
    op(0, 0, 0, "R11"); chk("R11", 48'(got), 48'hEF);

    cnt_in[15:0] = 16'h1357;
    op(1, 3, 8'h00, "R5"); chk("R5", 48'(mode_o[2:0]), 48'd2);
    cnt_in[15:0] = 16'h2468;
    op(0, 0, 0, "R9"); chk("R9", 48'(got), 48'h57);
    op(0, 0, 0, "R9"); chk("R9", 48'(got), 48'h13);
    op(0, 0, 0, "R9");

    cnt_in[15:0] = 16'hAAAA;
    op(1, 3, 8'h00, "R5");
    cnt_in[15:0] = 16'hBBBB;
    op(1, 3, 8'h00, "R6"); chk("R6", 48'(snap_stb), 0);
    op(0, 0, 0, "R6"); chk("R6", 48'(got), 48'hAA);
    op(0, 0, 0, "R6"); chk("R6", 48'(got), 48'hAA);

    cnt_in = 48'h5A5A_2222_1111; out_in = 3'b010;
    op(1, 3, 8'hC6, "R7");
    cnt_in[31:0] = 32'h3344_0000;
    op(0, 0, 0, "R8"); chk("R8", 48'(got), 48'h34);
    op(0, 0, 0, "R9"); chk("R9", 48'(got), 48'h11);
    op(0, 0, 0, "R9"); chk("R9", 48'(got), 48'h11);
    op(0, 1, 0, "R8"); chk("R8", 48'(got), 48'h94);
    op(0, 1, 0, "R9"); chk("R9", 48'(got), 48'h22);
    op(0, 1, 0, "R9"); chk("R9", 48'(got), 48'h44);
    op(1, 3, 8'hD8, "R7");
    cnt_in[47:32] = 16'h0F0F;
    op(0, 2, 0, "R7"); chk("R7", 48'(got), 48'h5A);
    op(0, 2, 0, "R7"); chk("R7", 48'(got), 48'h0F);
    out_in = 3'b001;
    op(1, 3, 8'hE2, "R6");
    out_in = 3'b000;
    op(1, 3, 8'hE2, "R6");
    op(0, 0, 0, "R6"); chk("R6", 48'(got), 48'hB4);
    op(0, 3, 0, "R10"); chk("R10", 48'(got), 0);

    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 9));
      bit [1:0] a = 2'($urandom_range(0, 2));
      bit [7:0] d = 8'($urandom);
      cnt_in = {16'($urandom), 16'($urandom), 16'($urandom)};
      out_in = 3'($urandom);
      if (r < 4)      op(0, 2'($urandom_range(0, 3)), 0, "R9");
      else if (r < 7) op(1, a, d, "R4");
      else            op(1, 3, d, "R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule